// File: doc/BRIEF.md
# Low-Power Clock Gating Sequencer

This block decides which clock domains of a chip receive a clock in each power mode, and it orders the steps that bring the chip back out of stop. A power-management controller drives a two-bit mode request. The controller also drives a wakeup event and a set of options that take effect in stop: power down the PLL, power down the oscillator, and skip the recovery waits. A board strap marks the chip as clocked from an external source. The block drives enables for the CPU, Flash, SRAM and peripheral clock domains. It also drives power enables for the PLL and the oscillator, and an enable for the clock output pin.

While it runs, the block accepts one request. It latches the requested mode and the stop options, and after one entry cycle it holds the low-power enable pattern until a wakeup arrives. The exit path depends on what stop left powered down. If the oscillator was off, the block first waits out its restart time. If the PLL was off, it then waits out the relock time. Both waits are skipped with fast wakeup or with an external clock. Every exit ends with a Flash-only warm-up window before the CPU clock returns. All wait lengths are parameters counted in reference-clock cycles.

Top module: `lpcg_top`

## Requirements
- R1: After synchronous reset the block is in its run state with all seven enable outputs at 1.
- R2: mode_req is encoded as 2'b00 run, 2'b01 wait, 2'b10 doze and 2'b11 stop. In the run state, a non-run value makes the block enter that mode on the next clock. While the block is out of the run state, further changes to mode_req have no effect.
- R3: In wait and doze, periph_clk_en, pll_pwr_en, osc_pwr_en and clkout_en are 1, and cpu_clk_en, flash_clk_en and sram_clk_en are 0.
- R4: In stop, cpu_clk_en, flash_clk_en, sram_clk_en and periph_clk_en are all 0. pll_pwr_en equals the inverse of stop_pll_off, and osc_pwr_en equals the inverse of stop_osc_off, as latched with the request.
- R5: In stop, clkout_en is 1 exactly when the PLL was kept powered (stop_pll_off = 0).
- R6: Every exit from a low-power mode ends with FLASH_WARM_CYC cycles (at least 16). In that window flash_clk_en and periph_clk_en are 1 and cpu_clk_en and sram_clk_en are 0. After it, the block returns to run with all enables at 1.
- R7: On a slow stop exit with the oscillator powered down, osc_pwr_en is 1 and the system clocks stay off for OSC_WAIT_CYC cycles. This wait comes before any PLL wait, so pll_pwr_en stays 0 during it if the PLL was also off.
- R8: On a slow stop exit with the PLL powered down, pll_pwr_en is 1 and the system clocks stay off for PLL_WAIT_CYC cycles before the Flash warm-up.
- R9: With fast_wake set, a stop exit skips both the oscillator wait and the PLL wait and goes straight to the Flash warm-up.
- R10: With ext_clk_mode set, a stop exit skips both the oscillator wait and the PLL wait.
- R11: A wakeup pulse that arrives during the entry cycle is held, and the exit starts right after the low-power state is reached, with no further wakeup.
- R12: A wakeup event while the block is in run has no effect: all enables stay 1, and a later low-power entry still waits for a fresh wakeup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req | input | 2 | Requested power mode (00 run, 01 wait, 10 doze, 11 stop) |
| wake | input | 1 | Wakeup event |
| stop_pll_off | input | 1 | Power down the PLL while in stop |
| stop_osc_off | input | 1 | Power down the oscillator while in stop |
| fast_wake | input | 1 | Skip the oscillator and PLL recovery waits |
| ext_clk_mode | input | 1 | Strap: chip is clocked externally, no recovery waits |
| cpu_clk_en | output | 1 | CPU clock domain enable |
| flash_clk_en | output | 1 | Flash clock domain enable |
| sram_clk_en | output | 1 | SRAM clock domain enable |
| periph_clk_en | output | 1 | Peripheral clock domain enable |
| pll_pwr_en | output | 1 | PLL power enable |
| osc_pwr_en | output | 1 | Oscillator power enable |
| clkout_en | output | 1 | Clock output pin enable |

## Verification
The bench counts the exact number of cycles from wakeup to the return of the CPU clock. Within that stretch it also counts how many cycles the Flash clock and the PLL power were on. A design that skipped the warm-up, ran the PLL wait ahead of the oscillator wait, or ignored fast wakeup or the external-clock strap would show a wrong count. Random mode changes during a low-power stay catch a design that keeps accepting requests outside run. A wakeup during the entry cycle catches a design that drops it and sleeps forever. A wakeup issued while running catches a design that carries a stale wakeup into the next sleep.

// File: rtl/lpcg_pkg.sv
`timescale 1ns/1ps
package lpcg_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_WAIT = 2'b01,
        MODE_DOZE = 2'b10,
        MODE_STOP = 2'b11
    } pmode_e;

    typedef enum logic [2:0] {
        SEQ_RUN,
        SEQ_ENTER,
        SEQ_LOWPWR,
        SEQ_OSC_WAIT,
        SEQ_PLL_WAIT,
        SEQ_FLASH_WARM
    } seq_state_e;

    typedef struct packed {
        logic pll_off;
        logic osc_off;
        logic fast;
        logic ext_clk;
    } stop_opt_t;

    typedef struct packed {
        logic cpu;
        logic flash;
        logic sram;
        logic periph;
        logic pll;
        logic osc;
        logic clkout;
    } clk_en_t;

    // A stop exit that must honour oscillator and PLL recovery time
    function automatic logic slow_exit(pmode_e m, stop_opt_t o);
        return (m == MODE_STOP) && !o.fast && !o.ext_clk;
    endfunction

endpackage

// File: rtl/lpcg_timer.sv
`timescale 1ns/1ps
module lpcg_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/lpcg_fsm.sv
`timescale 1ns/1ps
module lpcg_fsm
    import lpcg_pkg::*;
#(
    parameter int OSC_WAIT_CYC   = 64,
    parameter int PLL_WAIT_CYC   = 48,
    parameter int FLASH_WARM_CYC = 16,
    parameter int CNT_W          = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  pmode_e           mode_req,
    input  logic             wake,
    input  stop_opt_t        opt_in,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output seq_state_e       state,
    output pmode_e           mode_q,
    output stop_opt_t        opt_q
);
    localparam logic [CNT_W-1:0] OSC_LD   = CNT_W'(OSC_WAIT_CYC - 1);
    localparam logic [CNT_W-1:0] PLL_LD   = CNT_W'(PLL_WAIT_CYC - 1);
    localparam logic [CNT_W-1:0] FLASH_LD = CNT_W'(FLASH_WARM_CYC - 1);

    seq_state_e nxt;
    logic       pend;
    logic       slow;

    assign slow = slow_exit(mode_q, opt_q);

    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state)
            SEQ_RUN:    if (mode_req != MODE_RUN) nxt = SEQ_ENTER;
            SEQ_ENTER:  nxt = SEQ_LOWPWR;
            SEQ_LOWPWR: begin
                if (wake || pend) begin
                    tmr_load = 1'b1;
                    if (slow && opt_q.osc_off) begin
                        nxt = SEQ_OSC_WAIT;   tmr_val = OSC_LD;
                    end else if (slow && opt_q.pll_off) begin
                        nxt = SEQ_PLL_WAIT;   tmr_val = PLL_LD;
                    end else begin
                        nxt = SEQ_FLASH_WARM; tmr_val = FLASH_LD;
                    end
                end
            end
            SEQ_OSC_WAIT: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    if (opt_q.pll_off) begin
                        nxt = SEQ_PLL_WAIT;   tmr_val = PLL_LD;
                    end else begin
                        nxt = SEQ_FLASH_WARM; tmr_val = FLASH_LD;
                    end
                end
            end
            SEQ_PLL_WAIT: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    nxt      = SEQ_FLASH_WARM;
                    tmr_val  = FLASH_LD;
                end
            end
            SEQ_FLASH_WARM: if (tmr_done) nxt = SEQ_RUN;
            default:        nxt = SEQ_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_RUN;
            mode_q <= MODE_RUN;
            opt_q  <= '0;
            pend   <= 1'b0;
        end else begin
            state <= nxt;
            if (state == SEQ_RUN && mode_req != MODE_RUN) begin
                mode_q <= mode_req;
                opt_q  <= opt_in;
            end
            if (state == SEQ_ENTER) pend <= wake;
            else                    pend <= 1'b0;
        end
    end

    // R2: the latched mode cannot move while away from run
    p_hold_request_r2: assert property (@(posedge clk) disable iff (rst)
        (state != SEQ_RUN) |=> (mode_q == $past(mode_q)));

    // R11: a wakeup seen during entry starts the exit one cycle into low power
    p_held_wake_r11: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_ENTER && wake) |=> (state == SEQ_LOWPWR) ##1 (state != SEQ_LOWPWR));

    // R7: the oscillator wait only ever gives way to a later stage
    p_osc_first_r7: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_OSC_WAIT) |=> (state inside {SEQ_OSC_WAIT, SEQ_PLL_WAIT, SEQ_FLASH_WARM}));

    // R9 and R10: fast or externally clocked exits jump to the warm-up
    p_fast_skip_r9: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_LOWPWR && (opt_q.fast || opt_q.ext_clk))
            |=> (state inside {SEQ_LOWPWR, SEQ_FLASH_WARM}));
endmodule

// File: rtl/lpcg_decode.sv
`timescale 1ns/1ps
module lpcg_decode
    import lpcg_pkg::*;
(
    input  seq_state_e state,
    input  pmode_e     mode_q,
    input  stop_opt_t  opt_q,
    output clk_en_t    en
);
    always_comb begin
        en = '0;
        case (state)
            SEQ_RUN: en = '1;
            SEQ_FLASH_WARM: begin
                en        = '1;
                en.cpu    = 1'b0;
                en.sram   = 1'b0;
            end
            default: begin
                if (mode_q == MODE_STOP) begin
                    en.pll    = !opt_q.pll_off || (state == SEQ_PLL_WAIT);
                    en.osc    = !opt_q.osc_off || (state inside {SEQ_OSC_WAIT, SEQ_PLL_WAIT});
                    en.clkout = !opt_q.pll_off;
                end else begin
                    en.periph = 1'b1;
                    en.pll    = 1'b1;
                    en.osc    = 1'b1;
                    en.clkout = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/lpcg_top.sv
`timescale 1ns/1ps
module lpcg_top
    import lpcg_pkg::*;
#(
    parameter int OSC_WAIT_CYC   = 64,
    parameter int PLL_WAIT_CYC   = 48,
    parameter int FLASH_WARM_CYC = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_req,
    input  logic       wake,
    input  logic       stop_pll_off,
    input  logic       stop_osc_off,
    input  logic       fast_wake,
    input  logic       ext_clk_mode,
    output logic       cpu_clk_en,
    output logic       flash_clk_en,
    output logic       sram_clk_en,
    output logic       periph_clk_en,
    output logic       pll_pwr_en,
    output logic       osc_pwr_en,
    output logic       clkout_en
);
    localparam int MAX_A   = (OSC_WAIT_CYC > PLL_WAIT_CYC) ? OSC_WAIT_CYC : PLL_WAIT_CYC;
    localparam int MAX_CYC = (MAX_A > FLASH_WARM_CYC) ? MAX_A : FLASH_WARM_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int WRM_W   = $clog2(FLASH_WARM_CYC + 1);

    stop_opt_t        opt_in, opt_q;
    seq_state_e       state;
    pmode_e           mode_q;
    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    clk_en_t          en;

    assign opt_in = '{pll_off: stop_pll_off, osc_off: stop_osc_off,
                      fast: fast_wake, ext_clk: ext_clk_mode};

    lpcg_fsm #(
        .OSC_WAIT_CYC  (OSC_WAIT_CYC),
        .PLL_WAIT_CYC  (PLL_WAIT_CYC),
        .FLASH_WARM_CYC(FLASH_WARM_CYC),
        .CNT_W         (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .mode_req (pmode_e'(mode_req)),
        .wake     (wake),
        .opt_in   (opt_in),
        .tmr_done (tmr_done),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .state    (state),
        .mode_q   (mode_q),
        .opt_q    (opt_q)
    );

    lpcg_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    lpcg_decode u_dec (
        .state  (state),
        .mode_q (mode_q),
        .opt_q  (opt_q),
        .en     (en)
    );

    assign cpu_clk_en    = en.cpu;
    assign flash_clk_en  = en.flash;
    assign sram_clk_en   = en.sram;
    assign periph_clk_en = en.periph;
    assign pll_pwr_en    = en.pll;
    assign osc_pwr_en    = en.osc;
    assign clkout_en     = en.clkout;

    // Checker: consecutive cycles with Flash clocked and CPU gated
    logic [WRM_W-1:0] warm_cnt;
    always_ff @(posedge clk) begin
        if (rst)                            warm_cnt <= '0;
        else if (flash_clk_en && !cpu_clk_en) begin
            if (warm_cnt != WRM_W'(FLASH_WARM_CYC)) warm_cnt <= warm_cnt + 1'b1;
        end else                            warm_cnt <= '0;
    end

    // R6: CPU clock never returns before the full Flash warm-up
    p_flash_lead_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_clk_en) |-> (warm_cnt == WRM_W'(FLASH_WARM_CYC)));

    // R3: wait and doze keep peripherals clocked and the core gated
    p_doze_periph_r3: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_LOWPWR && mode_q != MODE_STOP)
            |-> (periph_clk_en && !cpu_clk_en && !flash_clk_en && !sram_clk_en));

    // R4: stop gates every system clock domain
    p_stop_gated_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_STOP && state inside {SEQ_ENTER, SEQ_LOWPWR, SEQ_OSC_WAIT, SEQ_PLL_WAIT})
            |-> !(cpu_clk_en || flash_clk_en || sram_clk_en || periph_clk_en));

    // R5: a kept PLL keeps the clock output alive in stop
    p_clkout_kept_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_STOP && state == SEQ_LOWPWR && pll_pwr_en) |-> clkout_en);
endmodule

// File: tb/lpcg_top_test.sv
`timescale 1ns/1ps
module lpcg_top_test;
    localparam int OSC_C   = 64;
    localparam int PLL_C   = 48;
    localparam int FLASH_C = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] mode_req = 2'b00;
    logic wake = 1'b0, stop_pll_off = 1'b0, stop_osc_off = 1'b0;
    logic fast_wake = 1'b0, ext_clk_mode = 1'b0;
    logic cpu_clk_en, flash_clk_en, sram_clk_en, periph_clk_en;
    logic pll_pwr_en, osc_pwr_en, clkout_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    lpcg_top #(.OSC_WAIT_CYC(OSC_C), .PLL_WAIT_CYC(PLL_C), .FLASH_WARM_CYC(FLASH_C)) uut (
        .clk(clk), .rst(rst), .mode_req(mode_req), .wake(wake),
        .stop_pll_off(stop_pll_off), .stop_osc_off(stop_osc_off),
        .fast_wake(fast_wake), .ext_clk_mode(ext_clk_mode),
        .cpu_clk_en(cpu_clk_en), .flash_clk_en(flash_clk_en), .sram_clk_en(sram_clk_en),
        .periph_clk_en(periph_clk_en), .pll_pwr_en(pll_pwr_en), .osc_pwr_en(osc_pwr_en),
        .clkout_en(clkout_en)
    );

    function automatic logic [6:0] en_vec();
        return {cpu_clk_en, flash_clk_en, sram_clk_en, periph_clk_en,
                pll_pwr_en, osc_pwr_en, clkout_en};
    endfunction

    // Expected {cpu,flash,sram,periph,pll,osc,clkout} while asleep
    function automatic logic [6:0] exp_sleep(logic [1:0] m, logic po, logic oo);
        if (m == 2'b11) return {4'b0000, !po, !oo, !po};
        return 7'b0001111;
    endfunction

    function automatic int exp_recover(logic [1:0] m, logic po, logic oo, logic fw, logic ex);
        bit slow = (m == 2'b11) && !fw && !ex;
        return (slow && oo ? OSC_C : 0) + (slow && po ? PLL_C : 0) + FLASH_C;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic scenario(input logic [1:0] m, input logic po, input logic oo,
                            input logic fw, input logic ex, input int idle, input bit early);
        int total = 0, fl = 0, pl_off = 0, sr = 0;
        @(negedge clk);
        mode_req = m; stop_pll_off = po; stop_osc_off = oo; fast_wake = fw; ext_clk_mode = ex;
        @(negedge clk);                    // entry cycle
        mode_req = 2'b00; stop_pll_off = 1'b0; stop_osc_off = 1'b0; fast_wake = 1'b0;
        ext_clk_mode = 1'b0;
        chk("R2 entry on request", {25'd0, en_vec()}, {25'd0, exp_sleep(m, po, oo)});
        if (early) wake = 1'b1;
        @(negedge clk);                    // low-power state
        wake = 1'b0;
        chk("R3/R4/R5 sleep enables", {25'd0, en_vec()}, {25'd0, exp_sleep(m, po, oo)});
        if (early) begin
            @(negedge clk);                // R11: exit already under way
        end else begin
            for (int i = 0; i < idle; i++) begin
                mode_req = 2'($urandom_range(3, 0));
                @(negedge clk);
                chk("R2 request ignored while asleep", {25'd0, en_vec()},
                    {25'd0, exp_sleep(m, po, oo)});
            end
            mode_req = 2'b00;
            wake = 1'b1;
            @(negedge clk);
            wake = 1'b0;
        end
        while (!cpu_clk_en && total < 1000) begin
            total++;
            if (flash_clk_en) fl++;
            if (!pll_pwr_en) pl_off++;
            if (sram_clk_en) sr++;
            @(negedge clk);
        end
        chk("R7/R8/R9/R10/R11 cycles to CPU clock", total, exp_recover(m, po, oo, fw, ex));
        chk("R6 Flash warm-up length", fl, FLASH_C);
        chk("R6 SRAM gated during exit", sr, 0);
        chk("R7 PLL held off during oscillator wait", pl_off,
            ((m == 2'b11) && !fw && !ex && oo && po) ? OSC_C : 0);
        chk("R6 back in run", {25'd0, en_vec()}, 32'h7f);
    endtask

    initial begin
        void'($urandom(32'h1badcafe));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset enables", {25'd0, en_vec()}, 32'h7f);

        // R12: wakeup during run does nothing
        wake = 1'b1;
        repeat (3) @(negedge clk);
        chk("R12 wake in run ignored", {25'd0, en_vec()}, 32'h7f);
        wake = 1'b0;
        scenario(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 5, 1'b0);   // R12 sleep still waits

        // Directed corners
        scenario(2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 3, 1'b0);   // doze ignores stop options
        scenario(2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 4, 1'b0);   // R7 then R8
        scenario(2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 2, 1'b0);   // R8 only
        scenario(2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 2, 1'b0);   // R7 only
        scenario(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 2, 1'b0);   // R5 clkout kept
        scenario(2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 2, 1'b0);   // R9
        scenario(2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 2, 1'b0);   // R10
        scenario(2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 0, 1'b1);   // R11 held wake in stop
        scenario(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b1);   // R11 held wake in wait

        // Random mix
        for (int k = 0; k < 40; k++) begin
            scenario(2'($urandom_range(3, 1)), 1'($urandom), 1'($urandom),
                     1'($urandom_range(3, 0) == 0), 1'($urandom_range(3, 0) == 0),
                     int'($urandom_range(6, 0)), 1'($urandom_range(4, 0) == 0));
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule